// File: doc/BRIEF.md
# Write-Through Invalidate Cache Coherence Controller

This block is the coherence engine for one private cache in a shared-bus multiprocessor. It keeps a small direct-mapped cache of single-word lines. Each line has a presence flag and a tag, so a line is either Valid or Invalid. The processor issues one read or write at a time and holds it until the controller pulses ready. Read hits are served locally. Read misses fetch the word with a bus read and install it. Every write is sent straight to memory as a bus write. The bus is won through a request/grant pair before any command is driven.

The controller also watches the shared bus through a snoop input. When another cache writes a word that is held here, the local copy is dropped. The next local read must then fetch the fresh value. Bus transactions are atomic and processed one at a time, so invalidations take effect in bus order.

Top module: `wti_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is 0, `bus_req` is 0 and `bus_cmd` is idle (2'b00); the first read of any line therefore misses.
- R2: A processor read whose line is Invalid, or whose tag differs, issues exactly one bus read (`bus_cmd` = 2'b01) at the request address. It returns `bus_rdata` on `cpu_rdata` with `cpu_ready` and leaves the line Valid with the new tag.
- R3: A processor read that hits a Valid line with a matching tag uses no bus transaction. It returns the cached word with `cpu_ready` on the second rising edge after the request is first seen.
- R4: Every processor write issues exactly one bus write (`bus_cmd` = 2'b10) carrying the request address and data, whether the line is Valid or not. `cpu_ready` follows the edge that samples `bus_ack`.
- R5: A write never allocates: after a write to an Invalid line, a read of that address still misses.
- R6: A write to a Valid line with a matching tag updates the local copy, so a following read hits and returns the written word.
- R7: A snooped bus write (`snp_valid`=1, `snp_wr`=1, `snp_src` different from `NODE_ID`) whose address matches a Valid line makes that line Invalid at the edge that samples it.
- R8: A snoop is ignored when it is a read (`snp_wr`=0), when `snp_src` equals `NODE_ID`, or when its tag differs from the stored one: the line stays Valid and the next read hits.
- R9: When a snoop invalidation and a processor read hit fall on the same line in the lookup cycle, the snoop wins. The read is served as a miss with a bus read.
- R10: `bus_req` is raised after a miss or write and is held until the transfer ends. A command is driven only after `bus_gnt` has been sampled high, stays with `bus_req` high, and both drop on the edge that samples `bus_ack`.
- R11: The cache is direct-mapped: index = address bits [5:2] and tag = bits [31:6]. A miss to an index replaces its old tag, so the old address misses afterwards.
- R12: `cpu_ready` is a one-cycle pulse per request, and a new request is not accepted in the cycle where `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address (word aligned) |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | 00 idle, 01 read, 10 write |
| bus_addr | output | 32 | Bus transaction address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | Memory completes the current transaction |
| snp_valid | input | 1 | A bus transaction is observed |
| snp_wr | input | 1 | Observed transaction is a write |
| snp_src | input | 2 | Node number of the observed master |
| snp_addr | input | 32 | Observed address |

## Verification
A read hit raises `cpu_ready` on the second edge after the request is first sampled. A miss or write raises `bus_req` one edge after the lookup and drives the command one edge after grant. That path reaches ready on the edge that samples `bus_ack`. A snoop takes effect on the edge that samples it, so a read issued afterwards sees the new state. The bench drives and samples only at falling edges and counts those edges from the request. It checks the hit latency as exactly two and counts bus reads and writes from its own bus model. For the collision case it places the snoop in the one cycle where the lookup is registered.

// File: rtl/wti_pkg.sv
package wti_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'b00,
    BUS_RD   = 2'b01,
    BUS_WR   = 2'b10
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_BREQ,
    ST_BXFER
  } ctl_state_e;
endpackage

// File: rtl/wti_tag_array.sv
module wti_tag_array #(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             snp_hit
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic             raw_hit;

  assign raw_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign snp_hit = snp_en && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  // A snoop invalidating the looked-up line in this cycle masks the hit.
  assign lk_hit  = raw_hit && !(snp_hit && (snp_idx == lk_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (fill_en) valid_q[fill_idx] <= 1'b1;
      if (snp_hit) valid_q[snp_idx]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end
endmodule

// File: rtl/wti_data_ram.sv
module wti_data_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wti_ctrl.sv
module wti_ctrl
  import wti_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] ram_q,
  output logic [ADDR_W-1:0] req_addr,
  output logic              fill_en,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  ctl_state_e        state_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              done;

  assign req_addr = req_addr_q;
  assign done     = (state_q == ST_BXFER) && bus_ack;
  assign fill_en  = done && !req_we_q;
  // Reads fill the line; writes refresh the copy only if the line is present.
  assign ram_we    = done && (!req_we_q || lk_hit);
  assign ram_wdata = req_we_q ? req_wdata_q : bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      cpu_ready   <= 1'b0;
      cpu_rdata   <= '0;
      bus_req     <= 1'b0;
      bus_cmd     <= BUS_IDLE;
      bus_addr    <= '0;
      bus_wdata   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req && !cpu_ready) begin
            req_we_q    <= cpu_we;
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
            state_q     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (!req_we_q && lk_hit) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= ram_q;
            state_q   <= ST_IDLE;
          end else begin
            bus_req <= 1'b1;
            state_q <= ST_BREQ;
          end
        end
        ST_BREQ: begin
          if (bus_gnt) begin
            bus_cmd   <= req_we_q ? BUS_WR : BUS_RD;
            bus_addr  <= req_addr_q;
            bus_wdata <= req_wdata_q;
            state_q   <= ST_BXFER;
          end
        end
        ST_BXFER: begin
          if (bus_ack) begin
            bus_cmd   <= BUS_IDLE;
            bus_req   <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_rdata <= req_we_q ? req_wdata_q : bus_rdata;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wti_snoop_ctrl.sv
module wti_snoop_ctrl
  import wti_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LINES   = 16,
  parameter int SRC_W   = 2,
  parameter int NODE_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              snp_valid,
  input  logic              snp_wr,
  input  logic [SRC_W-1:0]  snp_src,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [SRC_W-1:0] MY_ID = SRC_W'(NODE_ID);

  logic [ADDR_W-1:0] req_addr;
  logic              lk_hit;
  logic              fill_en;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_q;
  logic              snp_en;
  logic              snp_hit;
  bus_cmd_e          cmd_e;

  assign snp_en  = snp_valid && snp_wr && (snp_src != MY_ID);
  assign bus_cmd = cmd_e;

  wti_tag_array #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) tags_i (
    .clk      (clk),
    .rst      (rst),
    .lk_idx   (req_addr[OFF_W +: IDX_W]),
    .lk_tag   (req_addr[ADDR_W-1 -: TAG_W]),
    .lk_hit   (lk_hit),
    .fill_en  (fill_en),
    .fill_idx (req_addr[OFF_W +: IDX_W]),
    .fill_tag (req_addr[ADDR_W-1 -: TAG_W]),
    .snp_en   (snp_en),
    .snp_idx  (snp_addr[OFF_W +: IDX_W]),
    .snp_tag  (snp_addr[ADDR_W-1 -: TAG_W]),
    .snp_hit  (snp_hit)
  );

  wti_data_ram #(
    .DEPTH (LINES),
    .AW    (IDX_W),
    .DW    (DATA_W)
  ) data_i (
    .clk   (clk),
    .we    (ram_we),
    .waddr (req_addr[OFF_W +: IDX_W]),
    .wdata (ram_wdata),
    .raddr (cpu_addr[OFF_W +: IDX_W]),
    .rdata (ram_q)
  );

  wti_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .lk_hit    (lk_hit),
    .ram_q     (ram_q),
    .req_addr  (req_addr),
    .fill_en   (fill_en),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (cmd_e),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack)
  );
endmodule

// File: rtl/wti_snoop_ctrl_chk.sv
module wti_snoop_ctrl_chk
  import wti_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cpu_req,
  input logic       cpu_we,
  input logic       cpu_ready,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (bus_cmd == BUS_IDLE) && !cpu_ready && !bus_req);

  // R10
  cmd_holds_req_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != BUS_IDLE) |-> bus_req);

  // R10
  cmd_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_cmd != BUS_IDLE) && ($past(bus_cmd) == BUS_IDLE)) |-> $past(bus_gnt));

  // R4
  wr_from_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == BUS_WR) |-> (cpu_req && cpu_we));

  // R2
  rd_from_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == BUS_RD) |-> (cpu_req && !cpu_we));

  // R12
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
endmodule

bind wti_snoop_ctrl wti_snoop_ctrl_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_ready (cpu_ready),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_cmd   (bus_cmd)
);

// File: tb/wti_snoop_ctrl_tb_top.sv
module wti_snoop_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_gnt = 1'b0, bus_ack = 1'b0;
  logic [1:0]  bus_cmd;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic        snp_valid = 1'b0, snp_wr = 1'b0;
  logic [1:0]  snp_src = '0;
  logic [31:0] snp_addr = '0;

  always #10 clk = ~clk;

  wti_snoop_ctrl dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .snp_valid(snp_valid),
    .snp_wr(snp_wr), .snp_src(snp_src), .snp_addr(snp_addr)
  );

  int checks = 0, fails = 0;
  int n_rd = 0, n_wr = 0, lat_cnt = 0, bus_lat = 0;
  logic [31:0] last_wa, last_wd;
  logic [31:0] mem [64];
  bit   exp_v [16];
  int   exp_t [16];

  function automatic logic [31:0] mk_addr(int tg, int ix);
    return (32'(tg) << 6) | (32'(ix) << 2);
  endfunction

  function automatic int mix(logic [31:0] a);
    return int'({a[7:6], a[5:2]});
  endfunction

  task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  // Bus arbiter and memory model, driven at falling edges.
  always @(negedge clk) begin
    if (rst) begin
      bus_gnt = 1'b0; bus_ack = 1'b0; lat_cnt = 0;
    end else begin
      bus_gnt = bus_req;
      if (bus_cmd != 2'b00 && !bus_ack) begin
        if (lat_cnt >= bus_lat) begin
          bus_ack = 1'b1;
          chk(bus_req === 1'b1, "R10", "bus_req held during command", 32'(bus_req), 32'd1);
          if (bus_cmd == 2'b01) begin
            bus_rdata = mem[mix(bus_addr)];
            n_rd++;
          end else begin
            mem[mix(bus_addr)] = bus_wdata;
            n_wr++;
            last_wa = bus_addr;
            last_wd = bus_wdata;
          end
        end else begin
          lat_cnt++;
        end
      end else begin
        bus_ack = 1'b0;
        lat_cnt = 0;
      end
    end
  end

  task automatic cpu_op(bit we, int tg, int ix, logic [31:0] wd, bit race,
                        output logic [31:0] rd, output int lat, output int drd, output int dwr);
    int rd0 = n_rd, wr0 = n_wr;
    lat = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = mk_addr(tg, ix); cpu_wdata = wd;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      lat++;
      if (race && lat == 1) begin
        snp_valid = 1'b1; snp_wr = 1'b1; snp_src = 2'd2; snp_addr = mk_addr(tg, ix);
        mem[mix(mk_addr(tg, ix))] = 32'h7700_0000 + 32'(ix * 16 + tg);
      end
      if (race && lat == 2) snp_valid = 1'b0;
      if (cpu_ready) break;
    end
    chk(cpu_ready === 1'b1, "R12", "ready arrives", 32'(cpu_ready), 32'd1);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    snp_valid = 1'b0;
    drd = n_rd - rd0;
    dwr = n_wr - wr0;
  endtask

  task automatic do_read(int tg, int ix, bit race, string r);
    logic [31:0] rd; int lat, drd, dwr;
    bit hit = exp_v[ix] && exp_t[ix] == tg && !race;
    bus_lat = ix % 3;
    cpu_op(1'b0, tg, ix, 32'h0, race, rd, lat, drd, dwr);
    chk(rd === mem[mix(mk_addr(tg, ix))], r, "read data", rd, mem[mix(mk_addr(tg, ix))]);
    chk(drd == (hit ? 0 : 1), r, hit ? "hit uses no bus read" : "miss issues one bus read",
        32'(drd), hit ? 32'd0 : 32'd1);
    if (hit) chk(lat == 2, "R3", "hit latency", 32'(lat), 32'd2);
    chk(dwr == 0, r, "read issues no bus write", 32'(dwr), 32'd0);
    exp_v[ix] = 1'b1; exp_t[ix] = tg;
  endtask

  task automatic do_write(int tg, int ix, logic [31:0] wd, string r);
    logic [31:0] rd; int lat, drd, dwr;
    bus_lat = (ix + 1) % 3;
    cpu_op(1'b1, tg, ix, wd, 1'b0, rd, lat, drd, dwr);
    chk(dwr == 1, "R4", "one bus write", 32'(dwr), 32'd1);
    chk(drd == 0, r, "write issues no bus read", 32'(drd), 32'd0);
    chk(last_wa === mk_addr(tg, ix), "R4", "bus write address", last_wa, mk_addr(tg, ix));
    chk(last_wd === wd, "R4", "bus write data", last_wd, wd);
  endtask

  task automatic do_snoop(bit wr, int src, int tg, int ix);
    @(negedge clk);
    snp_valid = 1'b1; snp_wr = wr; snp_src = 2'(src); snp_addr = mk_addr(tg, ix);
    @(negedge clk);
    snp_valid = 1'b0;
    if (wr && src != 0) begin
      mem[mix(mk_addr(tg, ix))] = 32'h5000_0000 + 32'(ix * 17 + tg);
      if (exp_v[ix] && exp_t[ix] == tg) exp_v[ix] = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h0101;
    for (int i = 0; i < 16; i++) begin exp_v[i] = 1'b0; exp_t[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(cpu_ready === 1'b0, "R1", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
    chk(bus_req === 1'b0, "R1", "bus_req after reset", 32'(bus_req), 32'd0);
    chk(bus_cmd === 2'b00, "R1", "bus_cmd after reset", 32'(bus_cmd), 32'd0);

    // R1, R2, R3: every line starts Invalid, misses once, then hits
    for (int ix = 0; ix < 16; ix++) begin
      do_read(0, ix, 1'b0, "R2");
      do_read(0, ix, 1'b0, "R3");
    end

    // R4, R6, R5, R11: writes to present and absent lines, replacement
    for (int ix = 0; ix < 16; ix++) begin
      do_write(0, ix, 32'hD000_0000 | 32'(ix), "R6");
      do_read(0, ix, 1'b0, "R6");
      do_write(1, ix, 32'hD100_0000 | 32'(ix), "R5");
      do_read(1, ix, 1'b0, "R5");
      do_read(0, ix, 1'b0, "R11");
      do_read(1, ix, 1'b0, "R11");
    end

    // R8 then R7: ignored snoops keep the line, a matching foreign write drops it
    for (int ix = 0; ix < 16; ix++) begin
      do_read(2, ix, 1'b0, "R11");
      do_snoop(1'b1, 1 + ix % 3, 3, ix);
      do_snoop(1'b1, 0, 2, ix);
      do_snoop(1'b0, 1, 2, ix);
      do_read(2, ix, 1'b0, "R8");
      do_snoop(1'b1, 1 + ix % 3, 2, ix);
      do_read(2, ix, 1'b0, "R7");
    end

    // R9: snoop invalidation in the lookup cycle of a read hit
    for (int ix = 0; ix < 16; ix += 3) begin
      do_read(2, ix, 1'b0, "R3");
      do_read(2, ix, 1'b1, "R9");
      do_read(2, ix, 1'b0, "R9");
    end

    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule